// File: doc/BRIEF.md
# RTC alarm and update-cycle engine

This block is the timekeeping core of a real-time clock. It counts strobes from a 32 kHz oscillator and advances seconds, minutes and hours once per second. The time bytes are held either as two BCD digits or as plain binary, and the hour can be shown in 24-hour form or in 12-hour form with a PM flag. Every time the second advances, the block emits a one-cycle update-ended pulse. When the new time matches the three alarm bytes, it also emits an alarm pulse in the same cycle. An alarm byte can be made a wildcard.

A status output warns the host shortly before each update, so that it does not read the time while the time is changing. A set-mode input freezes the time so that software can load it. A divider-hold input stops the second counter. Releasing the hold starts the count at mid-second, so the first update follows half a second later. The host loads time and alarm bytes through a simple one-byte write port.

Top module: `rtc_alarm_update_engine`

## Requirements
- R1: After reset, the seconds, minutes and hours bytes are 0x00, the two pulse outputs are 0 and the update-in-progress output is 0. The alarm bytes reset to 0x00.
- R2: With the divider running and set mode off, an update happens on every TICKS_PER_SEC-th strobe. The update advances seconds by one, and `uf_pulse_o` is high for exactly the one clock cycle after the strobe that completes the second.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0. The decimal digit carry is correct (for example 0x09 becomes 0x10).
- R4: With `bin_mode_i`=0 a field is stored as BCD, with tens in bits 7:4 and units in bits 3:0. With `bin_mode_i`=1 it is stored as a plain binary number.
- R5: With `h24_mode_i`=0, bit 7 of the hours byte is the PM flag and the hour is shown as 1..12, where midnight and noon show as 12. 11 AM (0x11) advances to 12 PM (0x92), and 11 PM (0x91) advances to 12 AM (0x12).
- R6: `af_pulse_o` rises only together with `uf_pulse_o`. It does so when every alarm byte either equals the new time byte or has bits 7:6 = 11, which makes it a wildcard.
- R7: `uip_o` is 1 during the last UIP_TICKS strobe periods before each update. During the rest of the second it is 0.
- R8: While `set_mode_i`=1, no update occurs: the time does not advance and no pulse is emitted. During that time `uip_o` is 0 and `upd_irq_en_o` is 0. The strobe phase keeps counting.
- R9: While `div_hold_i`=1, no update occurs and `uip_o` is 0. After the hold is released, the first update comes on the TICKS_PER_SEC/2-th strobe.
- R10: `wr_sel_i` selects the target field: 0 seconds, 1 minutes, 2 hours, 4 alarm seconds, 5 alarm minutes, 6 alarm hours. Codes 3 and 7 change nothing. A write is visible the next cycle, wins over an update in the same cycle, and leaves the strobe phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per 32 kHz oscillator period |
| set_mode_i | input | 1 | Freeze time for loading |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| div_hold_i | input | 1 | Hold the second divider in reset |
| upd_irq_en_i | input | 1 | Update-interrupt enable request |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Target field code |
| wr_data_i | input | 8 | Byte to write |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| uip_o | output | 1 | Update in progress |
| uf_pulse_o | output | 1 | Update-ended pulse |
| af_pulse_o | output | 1 | Alarm-match pulse |
| upd_irq_en_o | output | 1 | Effective update-interrupt enable |

## Verification
Directed runs cross the minute, hour and midnight boundaries in BCD 24-hour, binary 24-hour and BCD 12-hour modes. The boundaries show whether the digit carry, the binary wrap and the AM/PM flip are each right. An alarm at midnight must fire exactly once, and an all-wildcard alarm must fire on every update; comparing the two separates exact matching from wildcard matching. Set mode, divider hold and release, and writes in the middle of a second are applied on their own, which shows whether the strobe phase, the half-second start and the freeze are kept apart. Random segments then mix random modes, writes to every field code, wildcard alarms and toggles of set and hold, checked every cycle against a model that counts time as integers.

// File: rtl/rtc_engine_pkg.sv
`timescale 1ns/1ps
package rtc_engine_pkg;

  localparam logic [2:0] SEL_TIME_BASE  = 3'd0;
  localparam logic [2:0] SEL_ALARM_BASE = 3'd4;
  localparam int         NUM_FIELDS     = 3;
  localparam logic [6:0] MINSEC_LIMIT   = 7'd60;
  localparam logic [6:0] LAST_HOUR      = 7'd23;

  // Field byte to its numeric value.
  function automatic logic [6:0] byte_to_val(input logic [7:0] b, input logic binary);
    logic [6:0] tens;
    tens = {3'b000, b[7:4]};
    if (binary) return b[6:0];
    return 7'((tens * 7'd10) + {3'b000, b[3:0]});
  endfunction

  // Numeric value to a field byte.
  function automatic logic [7:0] val_to_byte(input logic [6:0] v, input logic binary);
    if (binary) return {1'b0, v};
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  // Hours byte to an hour 0..23.
  function automatic logic [6:0] hour_to_val(input logic [7:0] b, input logic binary,
                                             input logic h24);
    logic [6:0] v;
    if (h24) return byte_to_val(b, binary);
    v = byte_to_val({1'b0, b[6:0]}, binary);
    return 7'(v % 7'd12) + (b[7] ? 7'd12 : 7'd0);
  endfunction

  // Hour 0..23 to an hours byte.
  function automatic logic [7:0] val_to_hour(input logic [6:0] v, input logic binary,
                                             input logic h24);
    logic [6:0] d;
    if (h24) return val_to_byte(v, binary);
    d = 7'(v % 7'd12);
    if (d == 7'd0) d = 7'd12;
    return val_to_byte(d, binary) | {(v >= 7'd12), 7'b0};
  endfunction

  // Seconds/minutes step: {carry, next byte}.
  function automatic logic [8:0] field_step(input logic [7:0] b, input logic binary,
                                            input logic [6:0] lim);
    logic [6:0] v;
    v = byte_to_val(b, binary);
    if (v + 7'd1 >= lim) return {1'b1, val_to_byte(7'd0, binary)};
    return {1'b0, val_to_byte(v + 7'd1, binary)};
  endfunction

  function automatic logic [7:0] hour_step(input logic [7:0] b, input logic binary,
                                           input logic h24);
    logic [6:0] v;
    v = hour_to_val(b, binary, h24);
    v = (v >= LAST_HOUR) ? 7'd0 : v + 7'd1;
    return val_to_hour(v, binary, h24);
  endfunction

  // Top two bits both set: the alarm byte matches anything.
  function automatic logic alarm_field_hit(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic set_i,
  output logic upd_o,
  output logic uip_o
);
  localparam int             CW        = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0]  LAST_PH   = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0]  HALF_PH   = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0]  UIP_START = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] ph_q;
  logic          at_last;

  assign at_last = (ph_q == LAST_PH);

  // A hold parks the phase at mid-second, so release leads to an update half a second later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= '0;
    else if (hold_i) ph_q <= HALF_PH;
    else if (tick_i) ph_q <= at_last ? '0 : ph_q + 1'b1;
  end

  assign upd_o = tick_i & ~hold_i & ~set_i & at_last;
  assign uip_o = ~hold_i & ~set_i & (ph_q >= UIP_START);
endmodule

// File: rtl/rtc_timekeep.sv
`timescale 1ns/1ps
module rtc_timekeep
  import rtc_engine_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] sec_d_o,
  output logic [7:0] min_d_o,
  output logic [7:0] hour_d_o
);
  logic [7:0]            cur   [NUM_FIELDS];
  logic [7:0]            nxt   [NUM_FIELDS];
  logic [7:0]            stepd [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] carry;

  assign carry[0] = upd_i;

  // Seconds and minutes share the 60-wrap step and ripple a carry.
  for (genvar i = 0; i < NUM_FIELDS - 1; i++) begin : g_minsec
    logic [8:0] r;
    assign r          = field_step(cur[i], bin_i, MINSEC_LIMIT);
    assign stepd[i]   = r[7:0];
    assign carry[i+1] = carry[i] & r[8];
  end
  assign stepd[NUM_FIELDS-1] = hour_step(cur[NUM_FIELDS-1], bin_i, h24_i);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [7:0] q;
    always_comb begin
      if (wr_en_i && wr_sel_i == SEL_TIME_BASE + 3'(i)) nxt[i] = wr_data_i;
      else if (carry[i])                                nxt[i] = stepd[i];
      else                                              nxt[i] = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt[i];
    end
    assign cur[i] = q;
  end

  assign sec_o    = cur[0];
  assign min_o    = cur[1];
  assign hour_o   = cur[2];
  assign sec_d_o  = nxt[0];
  assign min_d_o  = nxt[1];
  assign hour_d_o = nxt[2];
endmodule

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp
  import rtc_engine_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] t_sec_i,
  input  logic [7:0] t_min_i,
  input  logic [7:0] t_hour_i,
  output logic       hit_o
);
  logic [7:0]            tval [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] hit_v;

  assign tval[0] = t_sec_i;
  assign tval[1] = t_min_i;
  assign tval[2] = t_hour_i;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en_i && wr_sel_i == SEL_ALARM_BASE + 3'(i)) q <= wr_data_i;
    end
    assign hit_v[i] = alarm_field_hit(q, tval[i]);
  end

  assign hit_o = &hit_v;
endmodule

// File: rtl/rtc_alarm_update_engine.sv
`timescale 1ns/1ps
module rtc_alarm_update_engine #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       set_mode_i,
  input  logic       bin_mode_i,
  input  logic       h24_mode_i,
  input  logic       div_hold_i,
  input  logic       upd_irq_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       uip_o,
  output logic       uf_pulse_o,
  output logic       af_pulse_o,
  output logic       upd_irq_en_o
);
  logic       upd_evt;
  logic       alarm_hit;
  logic [7:0] sec_d, min_d, hour_d;

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(div_hold_i),
    .set_i(set_mode_i), .upd_o(upd_evt), .uip_o(uip_o));

  rtc_timekeep u_time (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_evt), .bin_i(bin_mode_i), .h24_i(h24_mode_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .sec_d_o(sec_d), .min_d_o(min_d), .hour_d_o(hour_d));

  // The alarm compares against the time value being loaded at this edge.
  rtc_alarm_cmp u_alm (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .t_sec_i(sec_d), .t_min_i(min_d), .t_hour_i(hour_d),
    .hit_o(alarm_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_pulse_o <= 1'b0;
      af_pulse_o <= 1'b0;
    end else begin
      uf_pulse_o <= upd_evt;
      af_pulse_o <= upd_evt & alarm_hit;
    end
  end

  assign upd_irq_en_o = upd_irq_en_i & ~set_mode_i;
endmodule

// File: rtl/rtc_engine_chk.sv
`timescale 1ns/1ps
module rtc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_i,
  input logic       hold_i,
  input logic       wr_en_i,
  input logic       upd_i,
  input logic       uip_i,
  input logic       uf_i,
  input logic       af_i,
  input logic       irq_en_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [7:0] hour_i
);
  AST_AF_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n) af_i |-> uf_i); // R6
  AST_UF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) uf_i |=> !uf_i); // R2
  AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !wr_en_i) |=> $stable({sec_i, min_i, hour_i})); // R2
  AST_UIP_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) upd_i |-> uip_i); // R7
  AST_SET_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n) set_i |-> !uip_i); // R8
  AST_SET_NO_UF: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> !uf_i); // R8
  AST_SET_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) set_i |-> !irq_en_i); // R8
  AST_HOLD_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n) hold_i |-> !uip_i); // R9
  AST_HOLD_NO_UF: assert property (@(posedge clk) disable iff (!rst_n) hold_i |=> !uf_i); // R9
endmodule

bind rtc_alarm_update_engine rtc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_i(set_mode_i), .hold_i(div_hold_i), .wr_en_i(wr_en_i),
  .upd_i(upd_evt), .uip_i(uip_o), .uf_i(uf_pulse_o), .af_i(af_pulse_o),
  .irq_en_i(upd_irq_en_o), .sec_i(sec_o), .min_i(min_o), .hour_i(hour_o));

// File: tb/rtc_alarm_update_engine_tb.sv
`timescale 1ns/1ps
module rtc_alarm_update_engine_tb;
  localparam int TPS  = 64;
  localparam int UIPT = 8;
  localparam int HALF = TPS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, set_mode_i = 1'b0, bin_mode_i = 1'b0, h24_mode_i = 1'b1;
  logic div_hold_i = 1'b0, upd_irq_en_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o;
  logic uip_o, uf_pulse_o, af_pulse_o, upd_irq_en_o;

  always #2.5 clk = ~clk;

  rtc_alarm_update_engine #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_mode_i(set_mode_i),
    .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .div_hold_i(div_hold_i),
    .upd_irq_en_i(upd_irq_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .uip_o(uip_o), .uf_pulse_o(uf_pulse_o), .af_pulse_o(af_pulse_o),
    .upd_irq_en_o(upd_irq_en_o));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // Bench-side drive state and model state
  bit r_set = 0, r_bin = 0, r_h24 = 1, r_hold = 0, r_uie = 0;
  bit w_en = 0; bit [2:0] w_sel = 0; bit [7:0] w_dat = 0;
  bit skip_time = 0, last_tk = 0;
  int tph = 0, m_ph = 0, m_s = 0, m_m = 0, m_h = 0;
  bit [7:0] m_as = 0, m_am = 0, m_ah = 0;
  bit exp_uf = 0, exp_af = 0;
  int uf_cnt = 0, af_cnt = 0;

  function automatic bit [7:0] enc(int v, bit bin);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int dec(bit [7:0] b, bit bin);
    if (bin) return int'(b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic bit [7:0] henc(int h, bit bin, bit h24);
    int d;
    if (h24) return enc(h, bin);
    d = (h % 12 == 0) ? 12 : h % 12;
    return enc(d, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction
  function automatic int hdec(bit [7:0] b, bit bin, bit h24);
    if (h24) return dec(b, bin);
    return (dec(b & 8'h7F, bin) % 12) + (b[7] ? 12 : 0);
  endfunction
  function automatic bit wild(bit [7:0] a);
    return a[7:6] == 2'b11;
  endfunction
  function automatic bit alarm_ok();
    return (wild(m_as) || dec(m_as, r_bin) == m_s) &&
           (wild(m_am) || dec(m_am, r_bin) == m_m) &&
           (wild(m_ah) || hdec(m_ah, r_bin, r_h24) == m_h);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit tk, upd;
    @(negedge clk);
    tk = (tph == 3); tph = (tph + 1) % 4; last_tk = tk;
    tick_i = tk; set_mode_i = r_set; bin_mode_i = r_bin; h24_mode_i = r_h24;
    div_hold_i = r_hold; upd_irq_en_i = r_uie;
    wr_en_i = w_en; wr_sel_i = w_sel; wr_data_i = w_dat;
    upd = tk && !r_hold && !r_set && (m_ph == TPS - 1);
    if (r_hold) m_ph = HALF;
    else if (tk) m_ph = (m_ph == TPS - 1) ? 0 : m_ph + 1;
    if (upd) begin
      m_s++;
      if (m_s == 60) begin m_s = 0; m_m++; end
      if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; end
    end
    if (w_en) case (w_sel)
      3'd0: m_s = dec(w_dat, r_bin);
      3'd1: m_m = dec(w_dat, r_bin);
      3'd2: m_h = hdec(w_dat, r_bin, r_h24);
      default: ;
    endcase
    exp_uf = upd;
    exp_af = upd && alarm_ok();
    if (w_en) case (w_sel)
      3'd4: m_as = w_dat;
      3'd5: m_am = w_dat;
      3'd6: m_ah = w_dat;
      default: ;
    endcase
    @(posedge clk); #1;
    if (!skip_time) begin
      chk(tag, sec_o, enc(m_s, r_bin));
      chk(tag, min_o, enc(m_m, r_bin));
      chk(tag, hour_o, henc(m_h, r_bin, r_h24));
    end
    chk("R2", uf_pulse_o, exp_uf);
    chk("R6", af_pulse_o, exp_af);
    chk("R7", uip_o, !r_hold && !r_set && (m_ph >= TPS - UIPT));
    chk("R8", upd_irq_en_o, r_uie && !r_set);
    if (uf_pulse_o) uf_cnt++;
    if (af_pulse_o) af_cnt++;
    w_en = 0;
  endtask

  task automatic wr(bit [2:0] sel, bit [7:0] dat);
    w_en = 1; w_sel = sel; w_dat = dat;
    step();
  endtask

  task automatic run_sec(int n);
    repeat (n * TPS * 4) step();
  endtask

  task automatic run_ticks(int n);
    int t = 0;
    while (t < n) begin step(); if (last_tk) t++; end
  endtask

  task automatic wait_uf();
    int g = 0;
    do begin step(); g++; end while (!uf_pulse_o && g < 4 * TPS * 4);
  endtask

  // Load a whole new mode and time under set mode so that no update sees mixed formats.
  task automatic load_all(bit bin, bit h24, int s, int m, int h,
                          bit [7:0] as, bit [7:0] am, bit [7:0] ah);
    bit sv = r_set;
    r_set = 1; skip_time = 1; r_bin = bin; r_h24 = h24;
    wr(3'd0, enc(s, bin)); wr(3'd1, enc(m, bin)); wr(3'd2, henc(h, bin, h24));
    skip_time = 0;
    wr(3'd4, as); wr(3'd5, am); wr(3'd6, ah);
    r_set = sv;
  endtask

  function automatic bit [7:0] rnd_alarm(int lim, bit hour);
    if ($urandom % 4 == 0) return 8'hC0 | 8'($urandom % 64);
    if (hour) return henc($urandom % lim, r_bin, r_h24);
    return enc($urandom % lim, r_bin);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired act=1 exp=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", sec_o, 0); chk("R1", min_o, 0); chk("R1", hour_o, 0);
    chk("R1", uf_pulse_o, 0); chk("R1", af_pulse_o, 0); chk("R1", uip_o, 0);

    // R3 BCD carry across midnight, alarm at 00:00:00
    tag = "R3";
    load_all(0, 1, 50, 59, 23, 8'h00, 8'h00, 8'h00);
    af_cnt = 0;
    run_sec(12);
    chk("R3", hour_o, 8'h00); chk("R3", min_o, 8'h00);
    chk("R6", af_cnt, 1);

    // R4 binary mode with all-wildcard alarm
    tag = "R4";
    load_all(1, 1, 58, 59, 23, 8'hC0, 8'hFF, 8'hC5);
    uf_cnt = 0; af_cnt = 0;
    run_sec(4);
    chk("R4", hour_o, 8'h00); chk("R4", min_o, 8'h00);
    chk("R6", af_cnt, uf_cnt);

    // R5 12-hour mode, AM->PM and PM->AM
    tag = "R5";
    load_all(0, 0, 58, 59, 11, 8'hC0, 8'hC0, 8'hC0);
    run_sec(3);
    chk("R5", hour_o, 8'h92);
    load_all(0, 0, 58, 59, 23, 8'h05, 8'hC0, 8'hC0);
    run_sec(3);
    chk("R5", hour_o, 8'h12);
    run_sec(8);

    // R8 set mode freezes time
    tag = "R8";
    r_set = 1; r_uie = 1; uf_cnt = 0;
    run_sec(3);
    chk("R8", uf_cnt, 0);
    r_set = 0; r_uie = 0;
    run_sec(1);

    // R9 divider hold and half-second release
    tag = "R9";
    r_hold = 1; uf_cnt = 0;
    run_sec(2);
    chk("R9", uf_cnt, 0);
    r_hold = 0; t = 0;
    do begin step(); if (last_tk) t++; end while (!uf_pulse_o && t < 2 * TPS);
    chk("R9", t, HALF);

    // R7 UIP window length in strobes
    tag = "R7";
    wait_uf(); t = 0;
    do begin step(); if (last_tk && uip_o) t++; end while (!uf_pulse_o);
    chk("R7", t, UIPT);

    // R10 ignored codes, write keeps phase
    tag = "R10";
    wr(3'd3, 8'h45); wr(3'd7, 8'h12);
    wait_uf();
    run_ticks(40);
    wr(3'd0, 8'h30);
    t = 0;
    do begin step(); if (last_tk) t++; end while (!uf_pulse_o && t < 2 * TPS);
    chk("R10", t, TPS - 40);
    chk("R10", sec_o, 8'h31);

    // Random segments
    for (int seg = 0; seg < 3; seg++) begin
      tag = "R3";
      r_set = 0; r_hold = 0;
      r_bin = $urandom % 2; r_h24 = $urandom % 2;
      load_all(r_bin, r_h24, $urandom % 60, $urandom % 60, $urandom % 24,
               rnd_alarm(60, 0), rnd_alarm(60, 0), rnd_alarm(24, 1));
      for (int k = 0; k < 20 * TPS * 4; k++) begin
        if ($urandom % 400 == 0) begin
          bit [2:0] s = 3'($urandom % 8);
          case (s)
            3'd0, 3'd1: wr(s, enc($urandom % 60, r_bin));
            3'd2:       wr(s, henc($urandom % 24, r_bin, r_h24));
            3'd4, 3'd5: wr(s, rnd_alarm(60, 0));
            3'd6:       wr(s, rnd_alarm(24, 1));
            default:    wr(s, 8'($urandom));
          endcase
        end else begin
          if ($urandom % 3000 == 0) r_set = !r_set;
          if ($urandom % 5000 == 0) r_hold = !r_hold;
          r_uie = $urandom % 2;
          step();
        end
      end
    end
    r_set = 0; r_hold = 0;
    run_sec(1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule